// File: doc/BRIEF.md
# Two-Tap Interleaved Carry-Save Product Accumulator

This block sums error-times-symbol products for the coefficient update of an adaptive equalizer. One accumulator datapath serves two taps. Its clock runs at twice the symbol rate, and valid beats alternate between the taps: even beats go to tap 0 and odd beats go to tap 1. Each tap keeps its running total as a redundant sum vector and carry vector. No carry ever ripples inside the loop.

After 16 symbols, which is 32 valid beats, the block copies both taps' redundant totals into output registers and raises a one-cycle completion flag. The next beat then starts a fresh block. A downstream stage resolves each total by adding the sum vector and the carry vector modulo 2^14.

Each stored digit is restricted to three encodings, so the value one has a single legal code. Signed products are not sign-extended by full adders. The sign bit of each product is inverted, and a constant offset is loaded into the accumulator when a block starts. Because of this, the bit slices above the product width contain only half adders.

Top module: `cs_prod_accum`

## Requirements
- R1: After a synchronous active-low reset, `done_o` is 0 and every bit of `sum_o` and `carry_o` is 0.
- R2: Valid beats alternate between taps. The first beat of a block goes to tap 0, the next to tap 1, and so on. Each product changes only the total of the tap it was assigned to.
- R3: `done_o` is high for exactly one cycle. It rises on the clock edge that accepts the 32nd valid beat of a block, counted from the block's first beat.
- R4: When `done_o` is high, for each tap t the value (`sum_o[t*14 +: 14]` + `carry_o[t*14 +: 14]`) mod 2^14 equals the two's-complement sum, modulo 2^14, of the 16 signed 8-bit products given to that tap in the block.
- R5: No stored or output digit position ever has sum bit 0 together with carry bit 1. Carry bit 0 of every tap is always 0.
- R6: A cycle with `prod_vld_i` low is not a beat. Its product is ignored, and the tap order and the totals are unchanged.
- R7: A valid beat with `blk_start_i` high throws away any partial block. That beat becomes the first beat of a new block, on tap 0. When `prod_vld_i` is low, `blk_start_i` has no effect.
- R8: Between two completions, `sum_o` and `carry_o` keep their values.
- R9: A block can follow a completion with no idle cycle and no `blk_start_i`. The first product of each tap replaces that tap's previous total instead of being added to it.
- R10: Sign handling is exact at the extremes. Sixteen products of -128 give 14336, and sixteen products of +127 give 2032.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the symbol rate |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_i | input | 8 | Signed error-times-symbol product |
| prod_vld_i | input | 1 | Marks a cycle that carries a product beat |
| blk_start_i | input | 1 | With a valid beat, begins a new block on tap 0 |
| sum_o | output | 28 | Captured sum vectors, tap t in bits t*14 +: 14 |
| carry_o | output | 28 | Captured carry vectors, same layout as `sum_o` |
| done_o | output | 1 | One-cycle pulse when the outputs hold a fresh block |

## Verification
Two events can fall in the same cycle. In one, the completion capture takes tap 1's total straight from the adder row. In the other, the first beat of the next block overwrites tap 0's state with the preload-based value.

The bench provokes this by streaming blocks back to back with no idle beat. It does this once without a start marker and once with one.

The scoreboard judges each case in two ways. The captured totals must match the modular sums of the finished block. The outputs must also stay unchanged while the new block overwrites the state registers.

// File: rtl/cs_acc_pkg.sv
// Shared helpers for the carry-save product accumulator.
// Assumes: all widths are positive, and the accumulator width is below 62 bits.
package cs_acc_pkg;

    // Width of an index that counts up to n-1, never narrower than one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Offset that cancels the inverted-sign trick over one block:
    // -(blk * 2^(p-1)) modulo 2^w.
    function automatic longint preload_value(input int w, input int p, input int blk);
        longint m;
        longint k;
        m = longint'(1) << w;
        k = (longint'(blk) << (p - 1)) % m;
        return (k == 0) ? longint'(0) : m - k;
    endfunction

endpackage

// File: rtl/cs_sign_prep.sv
// Turns a signed product into an offset-binary code by inverting its sign bit.
// Sign extension is therefore not needed: the accumulator's block preload
// removes the constant bias that this adds.
// Assumes: P >= 2.
module cs_sign_prep #(
    parameter int P = 8
) (
    input  logic [P-1:0] prod_i,
    output logic [P-1:0] code_o
);

    // Flip the sign bit and pass the magnitude bits through.
    always_comb begin
        code_o        = prod_i;
        code_o[P-1]   = ~prod_i[P-1];
    end

endmodule

// File: rtl/cs_csa_row.sv
// One carry-save addition row with digit recoding.
// The slices below P are full adders, because the addend reaches them.
// The slices at or above P are half adders, because the addend is zero there.
// The top slice keeps only its sum, since the total is taken modulo 2^W.
// Each digit is then recoded so that value one is always stored as (sum=1, carry=0).
// Assumes: W > P.
module cs_csa_row #(
    parameter int W = 14,
    parameter int P = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [P-1:0] x_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W-1:0] raw_s;
    logic [W-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i < P) begin : g_full
            // Full adder in a slice that the product reaches.
            assign raw_s[i]   = a_i[i] ^ b_i[i] ^ x_i[i];
            assign cin[i + 1] = (a_i[i] & b_i[i]) | (a_i[i] & x_i[i]) | (b_i[i] & x_i[i]);
        end else if (i < W - 1) begin : g_half
            // Half adder in a sign-extension slice.
            assign raw_s[i]   = a_i[i] ^ b_i[i];
            assign cin[i + 1] = a_i[i] & b_i[i];
        end else begin : g_top
            // Top slice: its carry-out falls outside the modulus.
            assign raw_s[i]   = a_i[i] ^ b_i[i];
        end
    end

    // Recode each digit: a lone one moves to the sum bit, and a two sets both bits.
    assign s_o = raw_s | cin;
    assign c_o = raw_s & cin;

endmodule

// File: rtl/cs_beat_seq.sv
// Beat sequencer: gives each valid beat to a tap and a symbol position.
// A valid beat with the start marker forces position (symbol 0, tap 0).
// The block wraps on its own after the final beat.
// Assumes: NTAP >= 1 and BLK >= 1.
module cs_beat_seq #(
    parameter int NTAP = 2,
    parameter int BLK  = 16,
    localparam int TW  = cs_acc_pkg::idx_width(NTAP),
    localparam int SW  = cs_acc_pkg::idx_width(BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic          start_i,
    output logic          beat_o,
    output logic [TW-1:0] tap_o,
    output logic          first_o,
    output logic          last_o
);

    logic [TW-1:0] tap_q;
    logic [TW-1:0] tap_eff;
    logic [SW-1:0] sym_q;
    logic [SW-1:0] sym_eff;

    // Position of the current beat, after any restart from the start marker.
    always_comb begin
        tap_eff = start_i ? '0 : tap_q;
        sym_eff = start_i ? '0 : sym_q;
        beat_o  = vld_i;
        tap_o   = tap_eff;
        first_o = (sym_eff == '0);
        last_o  = (sym_eff == SW'(BLK - 1)) && (tap_eff == TW'(NTAP - 1));
    end

    // Move to the next position on each valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
            sym_q <= '0;
        end else if (vld_i) begin
            if (tap_eff == TW'(NTAP - 1)) begin
                tap_q <= '0;
                sym_q <= last_o ? '0 : sym_eff + SW'(1);
            end else begin
                tap_q <= tap_eff + TW'(1);
                sym_q <= sym_eff;
            end
        end
    end

    // R6: a cycle without a valid beat leaves the position unchanged.
    a_r6_seq_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(tap_q) && $stable(sym_q)));

    // R2: a beat that is not the last tap of a symbol stays on the same symbol.
    a_r2_sym_kept_within_taps: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !start_i && (tap_q != TW'(NTAP - 1))) |=> (sym_q == $past(sym_q)));

    // R7: a start beat with more than one tap leaves symbol 0 current.
    a_r7_start_realigns: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && start_i && (NTAP > 1)) |=> (sym_q == '0));

endmodule

// File: rtl/cs_tap_bank.sv
// Per-tap redundant state registers and the operand select.
// On the first beat of a tap in a block, the preload constant replaces the
// stored state. Otherwise the selected tap's sum and carry feed the adder row.
// Assumes: tap_i is always below NTAP.
module cs_tap_bank #(
    parameter int          NTAP    = 2,
    parameter int          W       = 14,
    parameter logic [W-1:0] PRELOAD = '0,
    localparam int         TW      = cs_acc_pkg::idx_width(NTAP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [TW-1:0]   tap_i,
    input  logic            first_i,
    input  logic [W-1:0]    nxt_s_i,
    input  logic [W-1:0]    nxt_c_i,
    output logic [W-1:0]    op_s_o,
    output logic [W-1:0]    op_c_o,
    output logic [NTAP*W-1:0] all_s_o,
    output logic [NTAP*W-1:0] all_c_o
);

    logic [W-1:0] st_s [NTAP];
    logic [W-1:0] st_c [NTAP];

    // Choose the adder operands: the preload on a block's first beat, otherwise the stored state.
    always_comb begin
        op_s_o = first_i ? PRELOAD : st_s[tap_i];
        op_c_o = first_i ? '0      : st_c[tap_i];
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        // Write the new redundant total on a beat addressed to this tap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_s[t] <= '0;
                st_c[t] <= '0;
            end else if (wr_i && (tap_i == TW'(t))) begin
                st_s[t] <= nxt_s_i;
                st_c[t] <= nxt_c_i;
            end
        end

        assign all_s_o[t*W +: W] = st_s[t];
        assign all_c_o[t*W +: W] = st_c[t];

        // R5: the digit code (sum 0, carry 1) never reaches a register.
        a_r5_no_zero_one_code: assert property (@(posedge clk) disable iff (!rst_n)
            ((~st_s[t] & st_c[t]) == '0));

        // R5: no carry is ever stored into the least significant position.
        a_r5_lsb_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (st_c[t][0] == 1'b0));

        // R2: a tap's state moves only on beats addressed to it.
        a_r2_other_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && (tap_i == TW'(t))) |=> ($stable(st_s[t]) && $stable(st_c[t])));
    end

endmodule

// File: rtl/cs_prod_accum.sv
// Top level of the interleaved carry-save product accumulator.
// Connects the beat sequencer, the sign-offset coder, the tap state bank and
// the carry-save row, and captures both taps' totals when a block finishes.
// Assumes: the caller resolves sum + carry modulo 2^W downstream.
module cs_prod_accum #(
    parameter int W    = 14,
    parameter int P    = 8,
    parameter int BLK  = 16,
    parameter int NTAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P-1:0]      prod_i,
    input  logic              prod_vld_i,
    input  logic              blk_start_i,
    output logic [NTAP*W-1:0] sum_o,
    output logic [NTAP*W-1:0] carry_o,
    output logic              done_o
);

    localparam int           TW      = cs_acc_pkg::idx_width(NTAP);
    localparam logic [W-1:0] PRELOAD = W'(cs_acc_pkg::preload_value(W, P, BLK));

    logic              beat;
    logic              first;
    logic              last;
    logic [TW-1:0]     tap;
    logic [P-1:0]      code;
    logic [W-1:0]      op_s;
    logic [W-1:0]      op_c;
    logic [W-1:0]      nxt_s;
    logic [W-1:0]      nxt_c;
    logic [NTAP*W-1:0] all_s;
    logic [NTAP*W-1:0] all_c;

    cs_beat_seq #(
        .NTAP (NTAP),
        .BLK  (BLK)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (prod_vld_i),
        .start_i (blk_start_i),
        .beat_o  (beat),
        .tap_o   (tap),
        .first_o (first),
        .last_o  (last)
    );

    cs_sign_prep #(
        .P (P)
    ) i_sign (
        .prod_i (prod_i),
        .code_o (code)
    );

    cs_tap_bank #(
        .NTAP    (NTAP),
        .W       (W),
        .PRELOAD (PRELOAD)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (beat),
        .tap_i   (tap),
        .first_i (first),
        .nxt_s_i (nxt_s),
        .nxt_c_i (nxt_c),
        .op_s_o  (op_s),
        .op_c_o  (op_c),
        .all_s_o (all_s),
        .all_c_o (all_c)
    );

    cs_csa_row #(
        .W (W),
        .P (P)
    ) i_row (
        .a_i (op_s),
        .b_i (op_c),
        .x_i (code),
        .s_o (nxt_s),
        .c_o (nxt_c)
    );

    // Capture every tap's total on the final beat. The last tap comes straight from the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o   <= '0;
            carry_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= beat && last;
            if (beat && last) begin
                for (int t = 0; t < NTAP; t++) begin
                    if (t == NTAP - 1) begin
                        sum_o[t*W +: W]   <= nxt_s;
                        carry_o[t*W +: W] <= nxt_c;
                    end else begin
                        sum_o[t*W +: W]   <= all_s[t*W +: W];
                        carry_o[t*W +: W] <= all_c[t*W +: W];
                    end
                end
            end
        end
    end

    // R3: the completion flag never stays high for two cycles.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: a completion always follows an accepted beat.
    a_r3_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(prod_vld_i));

    // R8: the captured vectors change only together with a completion.
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(sum_o) && $stable(carry_o)));

    // R5: the captured vectors never show the code (sum 0, carry 1).
    a_r5_out_alphabet: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sum_o & carry_o) == '0));

endmodule

// File: tb/test_cs_prod_accum.sv
`timescale 1ns/1ps
module test_cs_prod_accum;

    localparam int W    = 14;
    localparam int P    = 8;
    localparam int BLK  = 16;
    localparam int NTAP = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [P-1:0]      prod = '0;
    logic              vld = 1'b0;
    logic              start = 1'b0;
    logic [NTAP*W-1:0] sum_o;
    logic [NTAP*W-1:0] carry_o;
    logic              done;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int acc [NTAP];
    bit finished = 1'b0;
    bit seen_done = 1'b0;
    bit prev_done = 1'b0;
    logic [NTAP*W-1:0] held_s;
    logic [NTAP*W-1:0] held_c;

    typedef struct {
        logic [W-1:0] v0;
        logic [W-1:0] v1;
        int           due;
        string        tag;
    } exp_t;

    exp_t sb[$];

    cs_prod_accum #(.W(W), .P(P), .BLK(BLK), .NTAP(NTAP)) i_cs_prod_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .prod_i      (prod),
        .prod_vld_i  (vld),
        .blk_start_i (start),
        .sum_o       (sum_o),
        .carry_o     (carry_o),
        .done_o      (done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [P-1:0] pick(input int mode, input int seed, input int sym, input int tap);
        int h;
        case (mode)
            1:       return (tap == 0) ? 8'h80 : 8'h7f;
            2:       return (tap == 0) ? P'(sym * 9 - 70) : '0;
            3:       return (tap == 0) ? P'(sym + 1) : P'(-(sym + 1) * 3);
            default: begin
                h = seed * 1103515245 + sym * 12345 + tap * 977 + 17;
                h = h ^ (h >>> 11);
                return P'(h);
            end
        endcase
    endfunction

    task automatic beat(input logic [P-1:0] p, input logic s, input logic v);
        @(negedge clk);
        prod  = p;
        start = s;
        vld   = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat('0, 1'b0, 1'b0);
    endtask

    // Driver: streams one block of 16 symbols for 2 taps and pushes the expected totals.
    task automatic run_block(input int mode, input int seed, input bit with_start, input bit gaps, input string tag);
        exp_t e;
        logic [P-1:0] p;
        for (int sym = 0; sym < BLK; sym++) begin
            for (int tap = 0; tap < NTAP; tap++) begin
                if (gaps && ((sym + tap) % 3 == 1)) begin
                    // R6 / R7: a non-beat with garbage data and a start marker must change nothing
                    beat(P'(seed + sym * 31), 1'b1, 1'b0);
                end
                p = pick(mode, seed, sym, tap);
                beat(p, with_start && (sym == 0) && (tap == 0), 1'b1);
                acc[tap] = ((sym == 0) ? 0 : acc[tap]) + int'($signed(p));
                if ((sym == BLK - 1) && (tap == NTAP - 1)) begin
                    e.v0  = W'(acc[0]);
                    e.v1  = W'(acc[1]);
                    e.due = cyc + 1;
                    e.tag = tag;
                    sb.push_back(e);
                end
            end
        end
    endtask

    // Monitor: pops the scoreboard on each completion and watches the held outputs in between.
    initial begin
        exp_t e;
        logic [W-1:0] tot;
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (done) begin
                    check(!prev_done, "R3", "done wider than one cycle", 1, 0);
                    if (sb.size() == 0) begin
                        check(1'b0, "R3", "unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(e.due == cyc, "R3", "done cycle", cyc, e.due);
                        tot = W'(sum_o[0 +: W] + carry_o[0 +: W]);
                        check(tot == e.v0, {e.tag, " R4"}, "tap0 total", int'(tot), int'(e.v0));
                        tot = W'(sum_o[W +: W] + carry_o[W +: W]);
                        check(tot == e.v1, {e.tag, " R4"}, "tap1 total", int'(tot), int'(e.v1));
                    end
                    for (int t = 0; t < NTAP; t++) begin
                        check(((~sum_o[t*W +: W] & carry_o[t*W +: W]) == '0) && (carry_o[t*W] == 1'b0),
                              "R5", "forbidden digit code", int'(carry_o[t*W +: W]), 0);
                    end
                    held_s    = sum_o;
                    held_c    = carry_o;
                    seen_done = 1'b1;
                end else begin
                    if (seen_done) begin
                        check((sum_o == held_s) && (carry_o == held_c), "R8", "outputs moved between completions",
                              int'(sum_o[W-1:0]), int'(held_s[W-1:0]));
                    end
                    if ((sb.size() > 0) && (sb[0].due < cyc)) begin
                        e = sb.pop_front();
                        check(1'b0, "R3", "missing done", 0, 1);
                    end
                end
                prev_done = done;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check((sum_o == '0) && (carry_o == '0), "R1", "vectors after reset", int'(sum_o[W-1:0]), 0);

        run_block(3, 0, 1'b1, 1'b0, "R2");        // distinct signed ramps per tap
        run_block(0, 5, 1'b0, 1'b0, "R9");        // back to back, no start: wrap and replace
        run_block(1, 0, 1'b1, 1'b0, "R10");       // -128 on tap 0, +127 on tap 1
        idle(6);                                   // R8 hold window
        for (int i = 0; i < 11; i++) beat(P'(i * 13 + 5), (i == 0), 1'b1);
        run_block(0, 9, 1'b1, 1'b0, "R7");        // restart mid-block discards partial sums
        idle(3);
        run_block(0, 21, 1'b1, 1'b1, "R6");       // non-beats with garbage and stray starts
        idle(2);
        run_block(2, 0, 1'b1, 1'b0, "R2");        // tap 1 carries only zeros
        run_block(0, 33, 1'b1, 1'b0, "R9");       // back to back with a start marker
        run_block(0, 47, 1'b0, 1'b0, "R4");
        idle(6);
        check(sb.size() == 0, "R3", "pending completions", sb.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule